// File: doc/BRIEF.md
# Serial-Loaded Output Control Register

This block receives one 8-bit control word over a three-wire serial link and holds it in an output register. The register enables eight low-side output drivers, one bit for each output. The controller pulls the active-low select line low and clocks in eight data bits, most significant bit first, sampling data on each serial-clock rising edge. It then raises the select line. The new word reaches the driver enables only on that rising edge, and only when exactly eight bits were clocked in. A frame of any other length is thrown away, and the previous setting stays in place.

The three serial pins are asynchronous to the system clock. They pass through synchronizer chains and are handled as edges in the system clock domain. The bit counter restarts on every falling edge of the select line. Serial-clock edges seen while select is high are ignored. The first output also has a parallel enable pin, which is ORed with its register bit. This pin is expected to have an external or internal pulldown, so an open pin reads as off. A synchronous system reset clears the register and gates every enable off for as long as it is held. The outputs stay off after reset until the controller writes a new word.

Top module: `serout_ctl_reg`

## Requirements
- R1: While `rst_n` is low, every bit of `drv_en` is 0.
- R2: Bits are shifted most significant bit first. The first bit clocked in lands in `drv_en[7]` and the eighth lands in `drv_en[0]`. A 1 turns an output on and a 0 turns it off.
- R3: While a frame is being shifted, `drv_en` keeps the previously committed value until the select line rises.
- R4: A frame with exactly 8 serial-clock rising edges commits its word on the select rising edge. A frame with fewer edges is discarded, and `drv_en` is unchanged.
- R5: A frame with more than 8 serial-clock rising edges is discarded, and `drv_en` is unchanged.
- R6: Serial-clock and data activity while `cs_n` is high changes neither the outputs nor the next frame's content.
- R7: `drv_en[0]` is the OR of register bit 0 and `out1_par_en`. `out1_par_en` has no effect on `drv_en[7:1]`.
- R8: Reset clears the register. After `rst_n` returns high, `drv_en[7:1]` is 0 and `drv_en[0]` follows `out1_par_en` alone, until a new word is committed.
- R9: The bit counter restarts on each falling edge of `cs_n`. A full frame that follows an aborted frame commits only its own eight bits.
- R10: A committed word appears on `drv_en` at the third rising clock edge after `cs_n` rises (with the default two synchronizer stages). It does not appear at the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; also gates all enables off while low |
| cs_n | input | 1 | Active-low frame select, asynchronous |
| sclk | input | 1 | Serial clock, sampled on its rising edge, asynchronous |
| sdi | input | 1 | Serial data, most significant bit first, asynchronous |
| out1_par_en | input | 1 | Parallel enable ORed into output 1 |
| drv_en | output | 8 | Low-side driver enables, bit 7 = output 8, bit 0 = output 1 |

## Verification
Two functions can act in the same clock cycle. One is a word commit that clears register bit 0. The other is the parallel-enable path, which holds output 1 on. The bench first loads a word with bit 0 set while `out1_par_en` is high. It then commits a word with bit 0 clear and samples `drv_en[0]` on every cycle of the commit window, so a glitch low fails the check. A second collision asserts reset while both the register and the parallel enable are driving outputs on. All enables must drop at once, and after release only the parallel path may be active.

// File: rtl/socr_pkg.sv
// Package: shared sizes for the serial-loaded output control register.
// Assumes: an 8-output default word and two-stage input synchronizers.
package socr_pkg;
    localparam int WORD_W_DEF = 8;
    localparam int SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/socr_sync.sv
// Module: socr_sync
// Brings N asynchronous single-bit inputs into the clk domain through a
// chain of STAGES flops for each bit. Each bit has its own reset value, so
// an idle-high select line does not produce a false edge after reset.
// Assumes: each input is stable for longer than STAGES clock periods.
module socr_sync #(
    parameter int N = 3,
    parameter int STAGES = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    generate
        for (genvar b = 0; b < N; b++) begin : g_bit
            logic [STAGES-1:0] chain_q;
            // Shift the raw input through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
                else        chain_q <= {chain_q[STAGES-2:0], d_i[b]};
            end
            assign q_o[b] = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/socr_shift.sv
// Module: socr_shift
// Detects edges on the synchronized select and serial clock. While select
// is low it shifts data in, MSB first, and counts bits; the count saturates
// one above the word length. On the select rising edge it raises commit_o
// for one cycle, but only if exactly WORD_W bits were counted.
// Assumes: inputs are already synchronized and mutually aligned.
module socr_shift #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    output logic              commit_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CAP  = CNT_W'(WORD_W + 1);

    logic              cs_prev_q, sclk_prev_q;
    logic              cs_rise, cs_fall, sclk_rise;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] shreg_q;

    // Remember last synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_prev_q   <= 1'b1;
            sclk_prev_q <= 1'b0;
        end else begin
            cs_prev_q   <= cs_n_s;
            sclk_prev_q <= sclk_s;
        end
    end

    assign cs_rise   = cs_n_s & ~cs_prev_q;
    assign cs_fall   = ~cs_n_s & cs_prev_q;
    assign sclk_rise = sclk_s & ~sclk_prev_q & ~cs_n_s;

    // Count serial-clock rising edges in the frame; restart when select falls.
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (cs_fall)                   cnt_q <= '0;
        else if (sclk_rise && cnt_q != CAP) cnt_q <= cnt_q + 1'b1;
    end

    // Shift serial data in, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)         shreg_q <= '0;
        else if (sclk_rise) shreg_q <= {shreg_q[WORD_W-2:0], sdi_s};
    end

    assign commit_o = cs_rise && (cnt_q == FULL);
    assign word_o   = shreg_q;

    // R5: the bit count never wraps past its saturation value.
    assert_cnt_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CAP);
    // R6: the shifter is frozen while select is high.
    assert_idle_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> $stable(shreg_q));
    // R9: the counter is zero right after a select falling edge.
    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> cnt_q == '0);
endmodule

// File: rtl/socr_outreg.sv
// Module: socr_outreg
// Holds the committed control word. It loads only on commit_i and is
// cleared by reset. It produces the driver enables: all are gated off
// while reset is low, and bit 0 is ORed with the parallel enable.
// Assumes: commit_i is a single-cycle pulse aligned with a valid word_i.
module socr_outreg #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              par_en_i,
    output logic [WORD_W-1:0] drv_o
);
    logic [WORD_W-1:0] ctl_q;

    // Load the committed word; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        ctl_q <= '0;
        else if (commit_i) ctl_q <= word_i;
    end

    generate
        for (genvar i = 0; i < WORD_W; i++) begin : g_drv
            if (i == 0) begin : g_par
                assign drv_o[i] = rst_n & (ctl_q[i] | par_en_i);
            end else begin : g_ser
                assign drv_o[i] = rst_n & ctl_q[i];
            end
        end
    endgenerate

    // R3: without a commit the register keeps its value.
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(ctl_q));
    // R8: a reset cycle leaves the register cleared.
    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> ctl_q == '0);
endmodule

// File: rtl/serout_ctl_reg.sv
// Module: serout_ctl_reg (top)
// Serial-loaded output control register. It synchronizes the serial pins,
// shifts a word, commits it when select rises after exactly WORD_W bits,
// and drives WORD_W low-side enables. Output 1 is also enabled by a
// parallel pin.
// Assumes: the serial clock and data are slow compared with clk (each
// level is held for several clk periods).
module serout_ctl_reg #(
    parameter int WORD_W = socr_pkg::WORD_W_DEF,
    parameter int SYNC_STAGES = socr_pkg::SYNC_STAGES_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              out1_par_en,
    output logic [WORD_W-1:0] drv_en
);
    logic [2:0]        sync_q;
    logic              commit;
    logic [WORD_W-1:0] word;

    socr_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs_n, sclk, sdi}),
        .q_o   (sync_q)
    );

    socr_shift #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_s   (sync_q[2]),
        .sclk_s   (sync_q[1]),
        .sdi_s    (sync_q[0]),
        .commit_o (commit),
        .word_o   (word)
    );

    socr_outreg #(.WORD_W(WORD_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .word_i   (word),
        .par_en_i (out1_par_en),
        .drv_o    (drv_en)
    );

    // R7: the parallel enable always holds output 1 on outside reset.
    assert_par_out1_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out1_par_en |-> drv_en[0]);
endmodule

// File: tb/tb_serout_ctl_reg.sv
// Directed bench for serout_ctl_reg: one task per scenario.
module tb_serout_ctl_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic       out1_par_en = 1'b0;
    logic [7:0] drv_en;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    serout_ctl_reg dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .out1_par_en(out1_par_en), .drv_en(drv_en)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drive a frame of n bits (MSB first from bit n-1) and raise select.
    task automatic send_bits(input logic [15:0] bits, input int n);
        cs_n = 1'b0;
        wait_neg(4);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = bits[i];
            wait_neg(4);
            sclk = 1'b1;
            wait_neg(4);
            sclk = 1'b0;
        end
        wait_neg(4);
        cs_n = 1'b1;
    endtask

    task automatic send_word(input logic [7:0] w);
        send_bits({8'h00, w}, 8);
        wait_neg(6);
    endtask

    task automatic t_reset;
        out1_par_en = 1'b1;
        wait_neg(3);
        chk("R1 outputs off in reset", drv_en, 8'h00);
        out1_par_en = 1'b0;
        rst_n = 1'b1;
        wait_neg(3);
        chk("R8 off after reset release", drv_en, 8'h00);
    endtask

    task automatic t_basic;
        send_word(8'h80);
        chk("R2 first bit is output 8", drv_en, 8'h80);
        send_word(8'h01);
        chk("R2 eighth bit is output 1", drv_en, 8'h01);
        send_word(8'hA5);
        chk("R4 exact 8-bit frame commits", drv_en, 8'hA5);
        send_word(8'h3C);
        chk("R4 second word commits", drv_en, 8'h3C);
    endtask

    task automatic t_hold;
        cs_n = 1'b0;
        wait_neg(4);
        for (int i = 7; i >= 0; i--) begin
            sdi = (i < 4);
            wait_neg(4);
            sclk = 1'b1;
            wait_neg(4);
            sclk = 1'b0;
        end
        wait_neg(8);
        chk("R3 held before select rises", drv_en, 8'h3C);
        cs_n = 1'b1;
        wait_neg(6);
        chk("R3 committed after select rises", drv_en, 8'h0F);
    endtask

    task automatic t_latency;
        send_bits(16'h0066, 8);
        wait_neg(2);
        chk("R10 not yet at second edge", drv_en, 8'h0F);
        wait_neg(1);
        chk("R10 visible at third edge", drv_en, 8'h66);
    endtask

    task automatic t_bad_length;
        send_bits(16'h001F, 5);
        wait_neg(6);
        chk("R4 short frame discarded", drv_en, 8'h66);
        send_bits(16'h01FF, 9);
        wait_neg(6);
        chk("R5 nine-bit frame discarded", drv_en, 8'h66);
        send_bits(16'h0AAA, 12);
        wait_neg(6);
        chk("R5 twelve-bit frame discarded", drv_en, 8'h66);
    endtask

    task automatic t_idle;
        for (int i = 0; i < 5; i++) begin
            sdi = i[0];
            wait_neg(4);
            sclk = 1'b1;
            wait_neg(4);
            sclk = 1'b0;
        end
        wait_neg(4);
        chk("R6 idle clocks ignored", drv_en, 8'h66);
        send_word(8'h5A);
        chk("R6 next frame unaffected", drv_en, 8'h5A);
    endtask

    task automatic t_restart;
        send_bits(16'h0007, 3);
        wait_neg(6);
        chk("R9 aborted frame discarded", drv_en, 8'h5A);
        send_word(8'hC3);
        chk("R9 full frame after abort", drv_en, 8'hC3);
    endtask

    task automatic t_out1;
        logic ok;
        send_word(8'h42);
        out1_par_en = 1'b1;
        #1;
        chk("R7 parallel enable sets output 1", drv_en, 8'h43);
        out1_par_en = 1'b0;
        #1;
        chk("R7 parallel enable released", drv_en, 8'h42);
        send_word(8'h41);
        out1_par_en = 1'b1;
        send_bits(16'h0040, 8);
        ok = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (drv_en[0] !== 1'b1) ok = 1'b0;
        end
        chk("R7 output 1 held through commit", {7'd0, ok}, 8'h01);
        chk("R7 others follow register", drv_en, 8'h41);
        out1_par_en = 1'b0;
        #1;
        chk("R7 serial bit 0 clear", drv_en, 8'h40);
    endtask

    task automatic t_reset_mid;
        send_word(8'hFF);
        out1_par_en = 1'b1;
        rst_n = 1'b0;
        #1;
        chk("R1 reset forces all off", drv_en, 8'h00);
        wait_neg(2);
        rst_n = 1'b1;
        out1_par_en = 1'b0;
        wait_neg(2);
        chk("R8 register cleared", drv_en, 8'h00);
        out1_par_en = 1'b1;
        #1;
        chk("R8 only parallel path active", drv_en, 8'h01);
        out1_par_en = 1'b0;
    endtask

    initial begin : watchdog
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait_neg(1);
        t_reset();
        t_basic();
        t_hold();
        t_latency();
        t_bad_length();
        t_idle();
        t_restart();
        t_out1();
        t_reset_mid();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule